// File: doc/BRIEF.md
# Register-Armed DAC SPI Master

This block lets software drive a 24-bit serial DAC through a handful of register-level signals. Software places a command word on the send input and raises an arm level. The block then runs one full-duplex SPI frame. It shifts the word out MSB first and, over the same frame, collects the word returned by the converter into a receive register. When the frame ends with arm still high, a finished flag is raised. Software drops arm to clear the flag and to make the block ready for the next frame.

An ownership selector chooses which master drives the converter pins. The register master is one choice, and a second on-chip master (a feedback loop) is the other; the loop's pins pass straight through when it owns the bus. An armed frame always runs to completion. When the register master does not own the pins, nothing it does reaches the converter and the bits it samples are zero.

The send and receive words are register levels, not streams. There is no valid/ready pair and no back-pressure. The only flow control is the level handshake between arm and finished. The SPI mode and the SCK divider are fixed by parameters.

Top module: `dac_spi_arm_master`

## Requirements
- R1: A rising arm seen while no frame is running starts a frame. The send word goes out on MOSI MSB first. The 24 bits sampled on MISO, with the first bit sampled landing in bit 23, become the receive word when the frame ends.
- R2: Lowering arm during a frame does not stop it. The frame completes, the receive word is still updated, and finished stays 0.
- R3: With arm held high, finished rises 2·WORD_W·HALF_DIV+1 clock edges after the edge that first samples arm high. The receive word updates on that same edge. Finished reads 0 in the same cycle that arm is low.
- R4: Finished is 0 whenever arm is low or a frame is in progress.
- R5: A new rising arm during a frame starts no second frame. Holding arm high after a frame ends starts no new frame either.
- R6: The send word is copied when the frame starts. Changing it during the frame does not alter the bits shifted out.
- R7: The receive word changes only at the end of a frame started by arm. Activity by the other master never changes it.
- R8: Select 2'b00 connects the register master to the DAC pins. Select 2'b10 passes alt_sck, alt_mosi and alt_cs_n straight to the DAC pins and returns dac_miso on alt_miso. alt_miso is 0 under any other select value.
- R9: If select is not 2'b00, an armed frame still runs, completes and raises finished. It drives no DAC pin, and it samples zeros, so the receive word becomes 0.
- R10: A register frame holds dac_cs_n low (active low) for exactly WORD_W SCK periods. SCK idles low, and each SCK half period lasts HALF_DIV clocks. MOSI changes on the falling SCK edge and MISO is sampled on the rising edge.
- R11: Select values 2'b01 and 2'b11 hold the DAC pins idle: dac_sck 0, dac_mosi 0 and dac_cs_n 1.
- R12: A synchronous active-low reset ends any frame. It raises dac_cs_n, clears finished and sets the receive word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 2 | Pin owner: 00 register master, 10 alternate master |
| arm | input | 1 | Arm level; a rising edge starts a frame |
| send_word | input | WORD_W | Word to transmit |
| recv_word | output | WORD_W | Word captured by the last armed frame |
| finished | output | 1 | Frame done while arm is still high |
| alt_sck | input | 1 | Alternate master SCK |
| alt_mosi | input | 1 | Alternate master MOSI |
| alt_cs_n | input | 1 | Alternate master chip select |
| alt_miso | output | 1 | MISO returned to the alternate master |
| dac_sck | output | 1 | SCK to DAC |
| dac_mosi | output | 1 | MOSI to DAC |
| dac_cs_n | output | 1 | Chip select to DAC, active low |
| dac_miso | input | 1 | MISO from DAC |

## Verification
The pin multiplexer has no register, so DAC pins and alt_miso follow sel and the alternate pins in the same cycle. The bench samples them shortly after driving, with no clock edge in between. Finished falls combinationally with arm and is checked 1 ns after arm is lowered. Finished and the receive word are due exactly 2·WORD_W·HALF_DIV+2 rising edges after arm is driven at a falling edge, and the bench checks that finished is still 0 one edge earlier. That places the counted edges (edge detect, shift engine, completion pulse, capture) exactly. A bus model samples MOSI, serves MISO and counts SCK edges inside each chip-select window.

// File: rtl/dsam_pkg.sv
package dsam_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_REG = 2'b00;
  localparam logic [SEL_W-1:0] SEL_ALT = 2'b10;

  typedef struct packed {
    logic sck;
    logic mosi;
    logic cs_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, cs_n: 1'b1};
endpackage

// File: rtl/dsam_shift_engine.sv
module dsam_shift_engine
  import dsam_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output spi_pins_t         pins
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic              busy_q, done_q, sck_q, tick;
  logic [CNT_W-1:0]  bit_q;
  logic [WORD_W-1:0] tx_q, rx_q;

  // half-period tick source: a divider only when one is needed
  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign tick = busy_q;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !busy_q)                     div_q <= '0;
        else if (div_q == DIV_W'(HALF_DIV - 1))    div_q <= '0;
        else                                       div_q <= div_q + 1'b1;
      end
      assign tick = busy_q && (div_q == DIV_W'(HALF_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          tx_q   <= tx_word;
          bit_q  <= '0;
          sck_q  <= 1'b0;
        end
      end else if (tick) begin
        sck_q <= ~sck_q;
        if (!sck_q) begin
          rx_q <= {rx_q[WORD_W-2:0], miso};
        end else begin
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
          if (bit_q == CNT_W'(WORD_W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign rx_word   = rx_q;
  assign pins.sck  = sck_q;
  assign pins.mosi = busy_q ? tx_q[WORD_W-1] : 1'b0;
  assign pins.cs_n = ~busy_q;
endmodule

// File: rtl/dsam_arm_ctrl.sv
module dsam_arm_ctrl #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start,
  output logic              finished,
  output logic [WORD_W-1:0] recv_word
);
  logic              arm_q, fin_q;
  logic [WORD_W-1:0] recv_q;

  assign start = arm && !arm_q && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      fin_q  <= 1'b0;
      recv_q <= '0;
    end else begin
      arm_q <= arm;
      if (!arm)      fin_q <= 1'b0;
      else if (done) fin_q <= 1'b1;
      if (done)      recv_q <= rx_word;
    end
  end

  // arm gates the flag directly so it drops in the cycle arm does
  assign finished  = fin_q && arm;
  assign recv_word = recv_q;
endmodule

// File: rtl/dsam_pin_mux.sv
module dsam_pin_mux
  import dsam_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  spi_pins_t        reg_pins,
  input  spi_pins_t        alt_pins,
  input  logic             dac_miso,
  output spi_pins_t        dac_pins,
  output logic             reg_miso,
  output logic             alt_miso
);
  always_comb begin
    dac_pins = PINS_IDLE;
    reg_miso = 1'b0;
    alt_miso = 1'b0;
    case (sel)
      SEL_REG: begin
        dac_pins = reg_pins;
        reg_miso = dac_miso;
      end
      SEL_ALT: begin
        dac_pins = alt_pins;
        alt_miso = dac_miso;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dac_spi_arm_master.sv
module dac_spi_arm_master
  import dsam_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              arm,
  input  logic [WORD_W-1:0] send_word,
  output logic [WORD_W-1:0] recv_word,
  output logic              finished,
  input  logic              alt_sck,
  input  logic              alt_mosi,
  input  logic              alt_cs_n,
  output logic              alt_miso,
  output logic              dac_sck,
  output logic              dac_mosi,
  output logic              dac_cs_n,
  input  logic              dac_miso
);
  logic              eng_start, eng_busy, eng_done, reg_miso;
  logic [WORD_W-1:0] eng_rx;
  spi_pins_t         reg_pins, alt_pins, dac_pins;

  assign alt_pins = '{sck: alt_sck, mosi: alt_mosi, cs_n: alt_cs_n};

  dsam_arm_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .busy(eng_busy), .done(eng_done),
    .rx_word(eng_rx), .start(eng_start), .finished(finished),
    .recv_word(recv_word)
  );

  dsam_shift_engine #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_word(send_word),
    .miso(reg_miso), .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
    .pins(reg_pins)
  );

  dsam_pin_mux u_mux (
    .sel(sel), .reg_pins(reg_pins), .alt_pins(alt_pins), .dac_miso(dac_miso),
    .dac_pins(dac_pins), .reg_miso(reg_miso), .alt_miso(alt_miso)
  );

  assign dac_sck  = dac_pins.sck;
  assign dac_mosi = dac_pins.mosi;
  assign dac_cs_n = dac_pins.cs_n;
endmodule

// File: rtl/dac_spi_arm_master_chk.sv
module dac_spi_arm_master_chk
  import dsam_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              finished,
  input logic [1:0]        sel,
  input logic              dac_sck,
  input logic              dac_mosi,
  input logic              dac_cs_n,
  input logic [WORD_W-1:0] recv_word,
  input logic              eng_busy,
  input logic              eng_done,
  input spi_pins_t         eng_pins
);
  localparam int EC_W = $clog2(WORD_W + 1) + 1;

  logic            sck_d;
  logic [EC_W-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      edge_cnt <= '0;
    end else begin
      sck_d <= eng_pins.sck;
      if (!eng_busy)                     edge_cnt <= '0;
      else if (eng_pins.sck && !sck_d)   edge_cnt <= edge_cnt + 1'b1;
    end
  end

  AST_FIN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> arm); // R4
  AST_FIN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !finished); // R4
  AST_FIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm) |-> !finished); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_done |=> $stable(recv_word)); // R7
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |-> (edge_cnt == EC_W'(WORD_W))); // R10
  AST_CS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_REG && !dac_cs_n) |-> eng_busy); // R8
  AST_UNDEF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_REG && sel != SEL_ALT) |-> (!dac_sck && !dac_mosi && dac_cs_n)); // R11
endmodule

bind dac_spi_arm_master dac_spi_arm_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .finished(finished), .sel(sel),
  .dac_sck(dac_sck), .dac_mosi(dac_mosi), .dac_cs_n(dac_cs_n),
  .recv_word(recv_word), .eng_busy(eng_busy), .eng_done(eng_done),
  .eng_pins(reg_pins)
);

// File: tb/dac_spi_arm_master_tb_top.sv
`timescale 1ns/1ps
module dac_spi_arm_master_tb_top;
  localparam int W  = 24;
  localparam int HD = 2;
  localparam int N  = 2 * W * HD + 2;  // falling-edge drive to finished

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [W-1:0] send_word = '0, recv_word;
  logic finished, alt_sck = 1'b0, alt_mosi = 1'b0, alt_cs_n = 1'b1, alt_miso;
  logic dac_sck, dac_mosi, dac_cs_n, dac_miso;

  int n_chk = 0, n_bad = 0;
  bit summary_done = 1'b0;

  // bus model of the converter
  logic [W-1:0] slv_word = '0, slv_rx = '0;
  int frames = 0, edge_total = 0, edge_base = 0, idx;

  always #10 clk = ~clk;

  dac_spi_arm_master #(.WORD_W(W), .HALF_DIV(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .arm(arm), .send_word(send_word),
    .recv_word(recv_word), .finished(finished), .alt_sck(alt_sck),
    .alt_mosi(alt_mosi), .alt_cs_n(alt_cs_n), .alt_miso(alt_miso),
    .dac_sck(dac_sck), .dac_mosi(dac_mosi), .dac_cs_n(dac_cs_n),
    .dac_miso(dac_miso)
  );

  always @(negedge dac_cs_n) begin
    frames    = frames + 1;
    edge_base = edge_total;
  end
  always @(posedge dac_sck) if (!dac_cs_n) begin
    slv_rx     = {slv_rx[W-2:0], dac_mosi};
    edge_total = edge_total + 1;
  end
  always_comb begin
    idx      = edge_total - edge_base;
    dac_miso = (!dac_cs_n && idx >= 0 && idx < W) ? slv_word[W-1-idx] : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // one armed frame with arm held high throughout
  task automatic full_frame(input logic [W-1:0] sw, input logic [W-1:0] sv);
    int f0;
    @(negedge clk);
    send_word = sw; slv_word = sv; arm = 1'b1; f0 = frames;
    repeat (N-1) @(negedge clk);
    chk(finished == 1'b0, "R3 finished early", 32'(finished), 0);
    chk(dac_cs_n == 1'b1, "R10 cs released", 32'(dac_cs_n), 1);
    @(negedge clk);
    chk(finished == 1'b1, "R3 finished due", 32'(finished), 1);
    chk(recv_word == sv, "R1 receive word", 32'(recv_word), 32'(sv));
    chk(slv_rx == sw, "R1 MOSI word", 32'(slv_rx), 32'(sw));
    chk(edge_total - edge_base == W, "R10 SCK count", 32'(edge_total - edge_base), W);
    chk(frames - f0 == 1, "R10 one frame", 32'(frames - f0), 1);
    arm = 1'b0; #1;
    chk(finished == 1'b0, "R3 drop with arm", 32'(finished), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int f0;
    logic [W-1:0] keep;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(finished == 1'b0, "R12 finished at reset", 32'(finished), 0);
    chk(recv_word == '0, "R12 recv at reset", 32'(recv_word), 0);
    chk(dac_cs_n == 1'b1 && dac_sck == 1'b0, "R12 pins idle", {dac_cs_n, dac_sck}, 2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R3/R10 sweep of data patterns
    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] a, b;
      a = W'((32'(i) * 32'h9E3779B1) >> 5);
      if (i == 0) a = '0;
      if (i == 1) a = '1;
      b = {a[11:0], a[23:12]} ^ 24'h5A5A5A;
      full_frame(a, b);
    end

    // R8 alt pass-through, all pin combinations
    keep = recv_word;
    @(negedge clk); sel = 2'b10;
    for (int c = 0; c < 8; c++) begin
      {alt_sck, alt_mosi, alt_cs_n} = 3'(c); #1;
      chk({dac_sck, dac_mosi, dac_cs_n} == 3'(c), "R8 alt pins", {dac_sck, dac_mosi, dac_cs_n}, c);
      chk(alt_miso == dac_miso, "R8 alt miso", 32'(alt_miso), 32'(dac_miso));
      @(negedge clk);
    end
    // R11 undefined selects keep DAC idle
    for (int s = 1; s < 4; s += 2) begin
      sel = 2'(s);
      for (int c = 0; c < 8; c++) begin
        {alt_sck, alt_mosi, alt_cs_n} = 3'(c); #1;
        chk({dac_sck, dac_mosi, dac_cs_n} == 3'b001, "R11 idle pins", {dac_sck, dac_mosi, dac_cs_n}, 1);
        chk(alt_miso == 1'b0, "R8 alt miso gated", 32'(alt_miso), 0);
        @(negedge clk);
      end
    end
    {alt_sck, alt_mosi, alt_cs_n} = 3'b001;
    chk(recv_word == keep, "R7 recv untouched by alt", 32'(recv_word), 32'(keep));

    // R9 armed frame while alt owns the pins
    sel = 2'b10; f0 = frames;
    send_word = 24'hC0FFEE; slv_word = 24'hFFFFFF; arm = 1'b1;
    repeat (40) @(negedge clk);
    chk(dac_cs_n == 1'b1, "R9 pins stay with alt", 32'(dac_cs_n), 1);
    repeat (N-40) @(negedge clk);
    chk(finished == 1'b1, "R9 finished", 32'(finished), 1);
    chk(recv_word == '0, "R9 zeros sampled", 32'(recv_word), 0);
    chk(frames == f0, "R9 no DAC frame", 32'(frames - f0), 0);
    arm = 1'b0; @(negedge clk); sel = 2'b00;

    // R2 arm dropped mid-frame
    f0 = frames; send_word = 24'h123456; slv_word = 24'h654321; arm = 1'b1;
    repeat (30) @(negedge clk); arm = 1'b0;
    repeat (N-30) @(negedge clk);
    chk(finished == 1'b0, "R2 finished stays low", 32'(finished), 0);
    chk(recv_word == 24'h654321, "R2 recv updated", 32'(recv_word), 32'h654321);
    chk(slv_rx == 24'h123456, "R2 frame completed", 32'(slv_rx), 32'h123456);

    // R5 re-arm mid-frame: no restart
    @(negedge clk);
    f0 = frames; send_word = 24'h0F0F0F; slv_word = 24'h00FF00; arm = 1'b1;
    repeat (30) @(negedge clk); arm = 1'b0;
    repeat (10) @(negedge clk); arm = 1'b1;
    repeat (N-40) @(negedge clk);
    chk(finished == 1'b1, "R5 finished with arm high", 32'(finished), 1);
    repeat (150) @(negedge clk);
    chk(frames - f0 == 1, "R5 single frame", 32'(frames - f0), 1);
    chk(finished == 1'b1, "R4 finished held", 32'(finished), 1);
    arm = 1'b0; @(negedge clk);

    // R6 send word changed mid-frame
    send_word = 24'h8C3E71; slv_word = 24'h1; arm = 1'b1;
    repeat (20) @(negedge clk); send_word = 24'h000000;
    repeat (N-20) @(negedge clk);
    chk(slv_rx == 24'h8C3E71, "R6 copied at start", 32'(slv_rx), 32'h8C3E71);
    chk(recv_word == 24'h1, "R1 recv after R6", 32'(recv_word), 1);
    arm = 1'b0; @(negedge clk);

    // R12 reset during a frame
    arm = 1'b1; slv_word = 24'hABCDEF;
    repeat (20) @(negedge clk);
    chk(finished == 1'b0, "R4 low while busy", 32'(finished), 0);
    rst_n = 1'b0; arm = 1'b0;
    repeat (2) @(negedge clk);
    chk(dac_cs_n == 1'b1, "R12 cs released", 32'(dac_cs_n), 1);
    chk(recv_word == '0, "R12 recv cleared", 32'(recv_word), 0);
    chk(finished == 1'b0, "R12 finished cleared", 32'(finished), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(dac_cs_n == 1'b1, "R12 idle after reset", 32'(dac_cs_n), 1);

    summary();
    $finish;
  end
endmodule